// File: doc/BRIEF.md
# Stack-Top Register Cache

This block keeps the top of a machine's data stack in registers so that an execution unit can work on it without going to memory. Sixteen words are held in a circular register file with a top pointer and a count of live entries. Depth 0 is always the top of stack. Each of several read ports picks any live entry with a 4-bit depth index, all in the same cycle. A 4-bit index is small enough to sit in a field of an 8-bit opcode.

A command port pops zero to three entries and may push one word in the same cycle. Popping two operands and pushing their combined result in one accepted command gives the effect of a three-operand operation. A separate write-back port stores a result into any live slot, selected by depth. When the cached region is full and a command would grow it, the deepest entry is spilled to an external word-wide memory. When a read or a pop needs an entry that is not cached, the missing word is filled back. Each memory transfer moves one word, so deep recursion costs one transfer per word and not a whole block.

The memory port is a simple request/ready handshake. The block stalls its command port while any transfer is requested. The entry count (DEPTH) must be a power of two. Popping more entries than the whole stack holds is not allowed.

Top module: `stk_cache`

## Requirements
- R1: After reset the stack is empty. cmd_ready is 1 for a command with no pops, every enabled read port shows rd_valid 0, and mem_req is 0.
- R2: Depth d on a read port (0 = top) returns the (d+1)-th most recently pushed word that is still live. rd_valid is combinational and is 1 in the same cycle when d is below the cached count. All ports answer independently in the same cycle.
- R3: An accepted push with pop_cnt 0 puts push_data at depth 0 from the next cycle on. Every older entry moves one depth deeper.
- R4: An accepted command with push_en 0 and pop_cnt k (1 to 3) removes the top k entries. The old depth k becomes depth 0.
- R5: An accepted command with push_en 1 and pop_cnt k removes k entries and then pushes push_data. With k = 1 the top entry is replaced and the count is unchanged. With k = 2 two operands are consumed and one result is left.
- R6: The cached count never exceeds DEPTH. A growing command at full count holds cmd_ready at 0 and raises mem_req with mem_we = 1. It writes the deepest cached word to address mem_addr, which equals the number of words already spilled. Memory word i holds stack element i counted from the bottom. The command is accepted after the spill.
- R7: While mem_req is 1 and mem_ready is 0, no transfer completes, no memory write happens, the cache state is held, and cmd_ready stays 0.
- R8: An enabled read of a depth at or beyond the cached count fills words from memory address (spilled count − 1) downward, one per transfer with mem_we = 0, until the depth is cached. Reading beyond the whole stack with memory empty leaves rd_valid 0 and mem_req 0.
- R9: A pop of more entries than are cached first fills the missing words from memory, then is accepted.
- R10: wb_en writes wb_data into the slot at wb_depth, counted before the cycle's command, if that depth is cached. Otherwise it is ignored. When the same slot is also written by an accepted push, the push wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Command pushes push_data |
| push_data | input | W | Word to push |
| pop_cnt | input | PCW | Entries to pop before the push |
| cmd_ready | output | 1 | Command accepted at this edge |
| wb_en | input | 1 | Write-back enable |
| wb_depth | input | log2(DEPTH) | Write-back depth |
| wb_data | input | W | Write-back word |
| rd_en | input | NRD | Read port enables |
| rd_depth | input | NRD×log2(DEPTH) | Read depth per port |
| rd_data | output | NRD×W | Read word per port |
| rd_valid | output | NRD | Read word is valid |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Spilled word |
| mem_rdata | input | W | Filled word, valid with mem_ready |
| mem_ready | input | 1 | Transfer completes at this edge |

## Verification
Reads are combinational, so read data and rd_valid are sampled one time step after the depth is driven. When a fill is needed, the check polls each falling edge until valid, because every fill costs at least one edge. A command takes effect at the rising edge where cmd_ready is seen high, so its result is checked by reads started at the following falling edge. Spill address and stall behaviour are checked one step after the memory's ready line falls, and held state is confirmed over several stalled cycles. The expected stack is an arithmetic model in the bench, and memory contents are compared word for word with its bottom.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_SPILL = 2'd1,
        XF_FILL  = 2'd2
    } xfer_e;
endpackage

// File: rtl/stk_rd_port.sv
module stk_rd_port #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int IDXW  = 4
) (
    input  logic [DEPTH-1:0][W-1:0] ent,
    input  logic [IDXW-1:0]         tp,
    input  logic [IDXW:0]           cnt,
    input  logic                    rd_en,
    input  logic [IDXW-1:0]         depth,
    output logic [W-1:0]            data,
    output logic                    valid,
    output logic                    miss
);
    logic [IDXW-1:0] slot;
    logic            live;

    always_comb begin
        slot  = tp - depth;
        live  = ({1'b0, depth} < cnt);
        data  = ent[slot];
        valid = rd_en && live;
        miss  = rd_en && !live;
    end
endmodule

// File: rtl/stk_xfer_ctl.sv
module stk_xfer_ctl
    import stk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDXW  = 4,
    parameter int AW    = 8,
    parameter int NRD   = 3,
    parameter int PCW   = 2
) (
    input  logic [IDXW:0]    cnt,
    input  logic [AW-1:0]    msp,
    input  logic             push_en,
    input  logic [PCW-1:0]   pop_cnt,
    input  logic [NRD-1:0]   rd_miss,
    input  logic             mem_ready,
    output xfer_e            kind,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic             xfer_done,
    output logic             cmd_ready
);
    localparam int CW = IDXW + 1;

    logic grows;
    logic full;
    logic spill_need;
    logic fill_need;
    logic short_pop;

    always_comb begin
        grows      = push_en && (pop_cnt == '0);
        full       = (cnt == CW'(DEPTH));
        short_pop  = (cnt < CW'(pop_cnt));
        spill_need = grows && full;
        fill_need  = (msp != '0) && !full && ((|rd_miss) || short_pop);
        if (spill_need)     kind = XF_SPILL;
        else if (fill_need) kind = XF_FILL;
        else                kind = XF_IDLE;
        mem_req   = (kind != XF_IDLE);
        mem_we    = (kind == XF_SPILL);
        mem_addr  = (kind == XF_SPILL) ? msp : (msp - AW'(1));
        xfer_done = mem_req && mem_ready;
        cmd_ready = !mem_req && !short_pop;
    end
endmodule

// File: rtl/stk_cache.sv
module stk_cache
    import stk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int NRD   = 3,
    parameter int AW    = 8,
    parameter int PCW   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push_en,
    input  logic [W-1:0]                       push_data,
    input  logic [PCW-1:0]                     pop_cnt,
    output logic                               cmd_ready,
    input  logic                               wb_en,
    input  logic [$clog2(DEPTH)-1:0]           wb_depth,
    input  logic [W-1:0]                       wb_data,
    input  logic [NRD-1:0]                     rd_en,
    input  logic [NRD-1:0][$clog2(DEPTH)-1:0]  rd_depth,
    output logic [NRD-1:0][W-1:0]              rd_data,
    output logic [NRD-1:0]                     rd_valid,
    output logic                               mem_req,
    output logic                               mem_we,
    output logic [AW-1:0]                      mem_addr,
    output logic [W-1:0]                       mem_wdata,
    input  logic [W-1:0]                       mem_rdata,
    input  logic                               mem_ready
);
    localparam int IDXW = $clog2(DEPTH);
    localparam int CW   = IDXW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [IDXW-1:0]         tp;
        logic [CW-1:0]           cnt;
        logic [AW-1:0]           msp;
    } st_t;

    st_t             st_d, st_q;
    xfer_e           xfer_kind;
    logic            xfer_done;
    logic            cmd_fire;
    logic [NRD-1:0]  rd_miss;
    logic [IDXW-1:0] spill_slot;
    logic [IDXW-1:0] fill_slot;
    logic [IDXW-1:0] new_tp;
    logic [CW-1:0]   cnt_q;
    logic [AW-1:0]   msp_q;

    assign cnt_q = st_q.cnt;
    assign msp_q = st_q.msp;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        stk_rd_port #(.W(W), .DEPTH(DEPTH), .IDXW(IDXW)) u_rd (
            .ent   (st_q.ent),
            .tp    (st_q.tp),
            .cnt   (st_q.cnt),
            .rd_en (rd_en[g]),
            .depth (rd_depth[g]),
            .data  (rd_data[g]),
            .valid (rd_valid[g]),
            .miss  (rd_miss[g])
        );
    end

    stk_xfer_ctl #(
        .DEPTH(DEPTH), .IDXW(IDXW), .AW(AW), .NRD(NRD), .PCW(PCW)
    ) u_xfer (
        .cnt       (st_q.cnt),
        .msp       (st_q.msp),
        .push_en   (push_en),
        .pop_cnt   (pop_cnt),
        .rd_miss   (rd_miss),
        .mem_ready (mem_ready),
        .kind      (xfer_kind),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .xfer_done (xfer_done),
        .cmd_ready (cmd_ready)
    );

    assign spill_slot = st_q.tp + IDXW'(1) - st_q.cnt[IDXW-1:0];
    assign fill_slot  = st_q.tp - st_q.cnt[IDXW-1:0];
    assign mem_wdata  = st_q.ent[spill_slot];
    assign cmd_fire   = cmd_ready && (push_en || (pop_cnt != '0));

    always_comb begin
        st_d   = st_q;
        new_tp = st_q.tp - IDXW'(pop_cnt);
        // write-back addresses the stack as it stands before this cycle
        if (wb_en && ({1'b0, wb_depth} < st_q.cnt)) begin
            st_d.ent[st_q.tp - wb_depth] = wb_data;
        end
        if (xfer_done && (xfer_kind == XF_SPILL)) begin
            st_d.cnt = st_q.cnt - CW'(1);
            st_d.msp = st_q.msp + AW'(1);
        end else if (xfer_done && (xfer_kind == XF_FILL)) begin
            st_d.ent[fill_slot] = mem_rdata;
            st_d.cnt = st_q.cnt + CW'(1);
            st_d.msp = st_q.msp - AW'(1);
        end
        // a command never coincides with a transfer: cmd_ready needs mem_req low
        if (cmd_fire) begin
            if (push_en) begin
                new_tp = new_tp + IDXW'(1);
                st_d.ent[new_tp] = push_data;
            end
            st_d.tp  = new_tp;
            st_d.cnt = st_q.cnt - CW'(pop_cnt) + CW'(push_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stk_cache_chk.sv
module stk_cache_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5,
    parameter int AW    = 8,
    parameter int PCW   = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  cnt,
    input logic [AW-1:0]  msp,
    input logic           cmd_ready,
    input logic           push_en,
    input logic [PCW-1:0] pop_cnt,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ready
);
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_no_grow_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && push_en && (pop_cnt == '0)) |-> (cnt < CW'(DEPTH)));

    assert_spill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=>
            ((cnt == $past(cnt) - CW'(1)) && (msp == $past(msp) + AW'(1))));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> ((cnt == $past(cnt)) && (msp == $past(msp))));

    assert_fill_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=>
            ((cnt == $past(cnt) + CW'(1)) && (msp == $past(msp) - AW'(1))));

    assert_pop_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && !push_en && (pop_cnt != '0)) |=>
            (cnt == $past(cnt) - CW'($past(pop_cnt))));

    assert_swap_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && push_en && (pop_cnt == PCW'(1))) |=> $stable(cnt));
endmodule

bind stk_cache stk_cache_chk #(
    .DEPTH(DEPTH), .CW(CW), .AW(AW), .PCW(PCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .msp       (msp_q),
    .cmd_ready (cmd_ready),
    .push_en   (push_en),
    .pop_cnt   (pop_cnt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready)
);

// File: tb/test_stk_cache.sv
`timescale 1ns/1ps
module test_stk_cache;
    localparam int W = 16, DEPTH = 16, NRD = 3, AW = 8, PCW = 2, IDXW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_en = 1'b0;
    logic [W-1:0] push_data = '0;
    logic [PCW-1:0] pop_cnt = '0;
    logic cmd_ready;
    logic wb_en = 1'b0;
    logic [IDXW-1:0] wb_depth = '0;
    logic [W-1:0] wb_data = '0;
    logic [NRD-1:0] rd_en = '0;
    logic [NRD-1:0][IDXW-1:0] rd_depth = '0;
    logic [NRD-1:0][W-1:0] rd_data;
    logic [NRD-1:0] rd_valid;
    logic mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [W-1:0] mem_wdata, mem_rdata;

    logic [W-1:0] mem [0:255];
    logic [W-1:0] ref_stk [0:255];
    int ref_sz = 0;
    int n_chk = 0, n_fail = 0, wr_cnt = 0, seq = 0;
    logic force_stall = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #10 clk = ~clk;

    stk_cache i_stk_cache (.*);

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= force_stall ? 1'b0 : (lfsr[0] | lfsr[2]);
    end
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign mem_rdata = mem[mem_addr];

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(bit pe, logic [W-1:0] d, int pc, string req, output int waits);
        @(negedge clk);
        push_en = pe; push_data = d; pop_cnt = PCW'(pc);
        #1;
        waits = 0;
        while (!cmd_ready && waits < 300) begin
            @(negedge clk); #1; waits++;
        end
        chk(req, "command accepted", int'(waits < 300), 1);
        @(posedge clk);
        #1;
        push_en = 1'b0; pop_cnt = '0;
        ref_sz -= pc;
        if (pe) begin ref_stk[ref_sz] = d; ref_sz++; end
    endtask

    task automatic push_n(int n, string req);
        int w;
        for (int i = 0; i < n; i++) begin
            seq++;
            do_cmd(1'b1, W'(seq * 37 + 11), 0, req, w);
        end
    endtask

    task automatic read_at(int p, int d, string req);
        int w = 0;
        @(negedge clk);
        rd_en[p] = 1'b1; rd_depth[p] = IDXW'(d);
        #1;
        while (!rd_valid[p] && w < 300) begin @(negedge clk); #1; w++; end
        chk(req, $sformatf("valid depth %0d", d), int'(rd_valid[p]), 1);
        chk(req, $sformatf("data depth %0d", d), int'(rd_data[p]), int'(ref_stk[ref_sz-1-d]));
        rd_en[p] = 1'b0;
    endtask

    task automatic verify_all(string req);
        for (int d = 0; d < ref_sz && d < DEPTH; d++) read_at(d % NRD, d, req);
    endtask

    task automatic read_absent(int d, string req);
        @(negedge clk);
        rd_en[0] = 1'b1; rd_depth[0] = IDXW'(d);
        repeat (4) @(negedge clk);
        #1;
        chk(req, "absent depth invalid", int'(rd_valid[0]), 0);
        chk(req, "absent depth no request", int'(mem_req), 0);
        rd_en[0] = 1'b0;
    endtask

    initial begin
        int w, wr0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk); rd_en = '1; rd_depth = '0; #1;
        chk("R1", "cmd_ready", int'(cmd_ready), 1);
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "mem_req", int'(mem_req), 0);
        rd_en = '0;
        // R3 pushes, R2 reads at every depth
        push_n(10, "R3");
        verify_all("R3");
        // R2 three ports in one cycle
        @(negedge clk);
        rd_en = '1; rd_depth[0] = 4'd0; rd_depth[1] = 4'd4; rd_depth[2] = 4'd9; #1;
        chk("R2", "all ports valid", int'(rd_valid), 7);
        chk("R2", "port0", int'(rd_data[0]), int'(ref_stk[ref_sz-1]));
        chk("R2", "port1", int'(rd_data[1]), int'(ref_stk[ref_sz-5]));
        chk("R2", "port2", int'(rd_data[2]), int'(ref_stk[ref_sz-10]));
        rd_en = '0;
        // R4 pops of 1..3
        for (int k = 1; k <= 3; k++) begin
            do_cmd(1'b0, '0, k, "R4", w);
            verify_all("R4");
        end
        // R5 replace top and two-operand combine
        do_cmd(1'b1, 16'h1234, 1, "R5", w);
        verify_all("R5");
        do_cmd(1'b1, 16'hC0DE, 2, "R5", w);
        verify_all("R5");
        // R6 grow past the cache; memory holds the bottom
        push_n(24 - ref_sz, "R6");
        chk("R6", "spill writes", wr_cnt, ref_sz - DEPTH);
        for (int i = 0; i < ref_sz - DEPTH; i++)
            chk("R6", $sformatf("memory word %0d", i), int'(mem[i]), int'(ref_stk[i]));
        verify_all("R6");
        // R7 stalled spill
        @(posedge clk); #1 force_stall = 1'b1;
        wr0 = wr_cnt;
        @(negedge clk);
        seq++; push_en = 1'b1; push_data = W'(seq * 37 + 11); pop_cnt = '0;
        for (int c = 0; c < 6; c++) begin
            #1;
            chk("R7", "cmd_ready held low", int'(cmd_ready), 0);
            chk("R6", "spill request", int'(mem_req && mem_we), 1);
            chk("R6", "spill address", int'(mem_addr), ref_sz - DEPTH);
            @(negedge clk);
        end
        chk("R7", "no write while stalled", wr_cnt, wr0);
        force_stall = 1'b0;
        w = 0;
        while (!cmd_ready && w < 300) begin @(negedge clk); #1; w++; end
        chk("R7", "accepted after stall", int'(w < 300), 1);
        @(posedge clk); #1 push_en = 1'b0;
        ref_stk[ref_sz] = push_data; ref_sz++;
        chk("R6", "spill count after stall", wr_cnt, wr0 + 1);
        verify_all("R7");
        // R8 pop deep, then reads fill back
        for (int k = 0; k < 5; k++) do_cmd(1'b0, '0, 3, "R8", w);
        verify_all("R8");
        read_absent(ref_sz, "R8");
        // R9 pop more than is cached
        push_n(20 - ref_sz, "R9");
        for (int k = 0; k < 5; k++) do_cmd(1'b0, '0, 3, "R9", w);
        do_cmd(1'b0, '0, 3, "R9", w);
        chk("R9", "pop waited for fill", int'(w > 0), 1);
        verify_all("R9");
        // R10 write-back
        push_n(5, "R10");
        verify_all("R10");
        @(negedge clk); wb_en = 1'b1; wb_depth = 4'd2; wb_data = 16'hBEEF;
        @(posedge clk); #1 wb_en = 1'b0;
        ref_stk[ref_sz-3] = 16'hBEEF;
        verify_all("R10");
        @(negedge clk); wb_en = 1'b1; wb_depth = IDXW'(ref_sz + 1); wb_data = 16'hDEAD;
        @(posedge clk); #1 wb_en = 1'b0;
        verify_all("R10");
        @(negedge clk); wb_en = 1'b1; wb_depth = 4'd0; wb_data = 16'h7777;
        push_en = 1'b1; push_data = 16'h4242; pop_cnt = 2'd1;
        @(posedge clk); #1 wb_en = 1'b0; push_en = 1'b0; pop_cnt = '0;
        ref_stk[ref_sz-1] = 16'h4242;
        verify_all("R10");
        @(negedge clk); wb_en = 1'b1; wb_depth = 4'd0; wb_data = 16'h5151;
        push_en = 1'b1; push_data = 16'h6161; pop_cnt = 2'd0;
        @(posedge clk); #1 wb_en = 1'b0; push_en = 1'b0;
        ref_stk[ref_sz-1] = 16'h5151; ref_stk[ref_sz] = 16'h6161; ref_sz++;
        verify_all("R10");
        // sweep of push/pop combinations across fill levels
        push_n(30 - ref_sz, "R6");
        for (int i = 0; i < 64; i++) begin
            int pc = i % 4;
            bit pe = ((i / 4) % 3) != 0;
            if (pc > ref_sz) pc = ref_sz;
            if (!pe && pc == 0) pc = 1;
            seq++;
            do_cmd(pe, W'(seq * 91 + 3), pc, pe ? "R5" : "R4", w);
            if (ref_sz < 6) push_n(12, "R3");
            read_at(0, 0, "R2");
            if (ref_sz > 7) read_at(1, 7, "R8");
        end
        verify_all("R2");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule